// File: doc/BRIEF.md
# Timestamp Counter with Deadline Timer

This block keeps a 64-bit timestamp for one core. An internal raw count advances by one on every clock where the tick enable is high. Software sees a visible counter, which is the raw count plus a signed 64-bit offset register, taken modulo 2^64. A one-shot deadline register arms a comparator. When the visible counter reaches the deadline, the block emits a single-cycle interrupt pulse, disarms itself and clears the deadline.

Software writes through one register-write port and reads through a combinational read port. If software writes the counter directly, the block keeps the raw count running and changes the offset so that the counter holds the written value. If software writes the offset, the visible counter moves with it. The comparator always works on the live visible counter, in full 64-bit unsigned arithmetic. An offset near a 32-bit boundary, or a negative offset, therefore gives neither a stuck timer nor an interrupt storm.

Top module: `tsc_deadline_timer`

## Requirements
- R1: After reset, the counter, offset and deadline all read zero, the armed bit reads 0 and irq_o is low.
- R2: The visible counter equals raw + offset modulo 2^64. The raw count advances by exactly one on each clock edge where tick_en_i is high and holds while it is low. Register writes are accepted in both cases.
- R3: A write with select 0 makes the counter read the written value after that edge. The offset becomes the written value minus the raw count after that edge, so writing zero to a running counter drives the offset negative.
- R4: A write with select 1 stores the full 64-bit signed offset, which then reads back unchanged. The visible counter moves by the change in offset.
- R5: While armed, irq_o goes high for one cycle after the first edge at which counter >= deadline, compared as 64-bit unsigned. A deadline at or below the counter fires on the next edge.
- R6: On firing, the deadline reads zero and the armed bit clears. Exactly one pulse comes per arm, and there is none until a nonzero deadline is written again.
- R7: Writing zero to the deadline (select 2) disarms the timer. No interrupt follows, even when the old deadline was due in that cycle. Writing a nonzero deadline arms the timer and replaces any pending one.
- R8: The comparator uses the current visible counter, not a value latched when the timer was armed. An offset change after arming moves the firing point by exactly that change.
- R9: The read select works as follows: 0 returns the counter, 1 the offset, 2 the deadline, and 3 a status word with the armed bit in bit 0 and zero in all other bits. Writes with select 3 change nothing.
- R10: Offsets 0x0000_0000_8000_0000, 0xFFFF_FFFF_0000_0000, 0xFFFF_FFFE_0000_0000 and other values near a 32-bit boundary give exactly one interrupt at the correct cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Allows the raw count to advance |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register selected for the write |
| wr_data_i | input | 64 | Write data |
| rd_sel_i | input | 2 | Register selected for the read |
| rd_data_o | output | 64 | Read data, combinational |
| irq_o | output | 1 | Single-cycle deadline interrupt |

## Verification
The bench mixes random writes with random tick enables. Deadline values are chosen just above, just below and far from the live counter, so the bench can tell an early firing from a late one and from a firing that never comes. Offset writes use values at 32-bit boundaries and negative values, where a 32-bit compare or a wrong sign extension would give a storm or a lost interrupt. Counter writes test whether the offset takes up the difference. Directed runs cover three more cases: disarming with zero, shifting the offset while armed, and a deadline write in the same cycle that the old deadline becomes due.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT    = 2'd0,
    SEL_ADJUST   = 2'd1,
    SEL_DEADLINE = 2'd2,
    SEL_STATUS   = 2'd3
  } tsc_sel_e;
endpackage

// File: rtl/tsc_raw_counter.sv
module tsc_raw_counter #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_en_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] raw_next_o
);
  logic [W-1:0] raw_q;

  assign raw_next_o = tick_en_i ? raw_q + W'(1) : raw_q;
  assign raw_o      = raw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= raw_next_o;
  end

  AST_RAW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_en_i |=> $stable(raw_q)); // R2
  AST_RAW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_en_i |=> raw_q == $past(raw_q) + W'(1)); // R2
endmodule

// File: rtl/tsc_adjust_reg.sv
module tsc_adjust_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cnt_wr_i,
  input  logic         adj_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] raw_next_i,
  output logic [W-1:0] adj_o
);
  logic [W-1:0] adj_q;

  // counter write: offset absorbs difference so raw + offset == written value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       adj_q <= '0;
    else if (cnt_wr_i) adj_q <= wdata_i - raw_next_i;
    else if (adj_wr_i) adj_q <= wdata_i;
  end

  assign adj_o = adj_q;

  AST_ADJ_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_wr_i && !cnt_wr_i |=> adj_q == $past(wdata_i)); // R4
endmodule

// File: rtl/tsc_deadline_cmp.sv
module tsc_deadline_cmp #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dl_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] visible_i,
  output logic [W-1:0] deadline_o,
  output logic         armed_o,
  output logic         irq_o
);
  logic [W-1:0] deadline_q;
  logic         armed_q;
  logic         irq_q;
  logic         due;
  logic         fire;

  // full-width unsigned compare against live counter
  assign due  = visible_i >= deadline_q;
  assign fire = armed_q && due && !dl_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      deadline_q <= '0;
      armed_q    <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      irq_q <= fire;
      if (dl_wr_i) begin
        deadline_q <= wdata_i;
        armed_q    <= |wdata_i;
      end else if (fire) begin
        deadline_q <= '0;
        armed_q    <= 1'b0;
      end
    end
  end

  assign deadline_o = deadline_q;
  assign armed_o    = armed_q;
  assign irq_o      = irq_q;

  AST_IRQ_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(armed_q)); // R5
  AST_FIRE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && due && !dl_wr_i |=> irq_q && !armed_q && deadline_q == '0); // R6
  AST_ZERO_DISARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dl_wr_i && wdata_i == '0 |=> !armed_q && !irq_q); // R7
  AST_NO_REPEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q && !$past(dl_wr_i) |=> !irq_q); // R6
endmodule

// File: rtl/tsc_deadline_timer.sv
module tsc_deadline_timer
  import tsc_pkg::*;
#(
  parameter int unsigned W     = 64,
  localparam int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [W-1:0]     rd_data_o,
  output logic             irq_o
);
  logic [W-1:0] raw, raw_next, adj, visible, deadline;
  logic         armed;
  logic         cnt_wr, adj_wr, dl_wr;

  assign cnt_wr = wr_en_i && (tsc_sel_e'(wr_sel_i) == SEL_COUNT);
  assign adj_wr = wr_en_i && (tsc_sel_e'(wr_sel_i) == SEL_ADJUST);
  assign dl_wr  = wr_en_i && (tsc_sel_e'(wr_sel_i) == SEL_DEADLINE);

  tsc_raw_counter #(.W(W)) i_raw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_en_i  (tick_en_i),
    .raw_o      (raw),
    .raw_next_o (raw_next)
  );

  tsc_adjust_reg #(.W(W)) i_adj (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_wr_i   (cnt_wr),
    .adj_wr_i   (adj_wr),
    .wdata_i    (wr_data_i),
    .raw_next_i (raw_next),
    .adj_o      (adj)
  );

  assign visible = raw + adj;

  tsc_deadline_cmp #(.W(W)) i_dl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dl_wr_i    (dl_wr),
    .wdata_i    (wr_data_i),
    .visible_i  (visible),
    .deadline_o (deadline),
    .armed_o    (armed),
    .irq_o      (irq_o)
  );

  always_comb begin
    unique case (tsc_sel_e'(rd_sel_i))
      SEL_COUNT:    rd_data_o = visible;
      SEL_ADJUST:   rd_data_o = adj;
      SEL_DEADLINE: rd_data_o = deadline;
      default:      rd_data_o = {{(W-1){1'b0}}, armed};
    endcase
  end

  AST_CNT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> visible == $past(wr_data_i)); // R3
  AST_STATUS_WR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == 2'd3 |=> adj == $past(adj)); // R9
endmodule

// File: tb/test_tsc_deadline_timer.sv
module test_tsc_deadline_timer;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [63:0] wr_data_i = '0;
  logic [1:0]  rd_sel_i = '0;
  logic [63:0] rd_data_o;
  logic        irq_o;

  int unsigned errors = 0;
  int unsigned checks = 0;
  int unsigned irq_seen = 0;
  bit          done = 1'b0;

  logic [63:0] raw_m = '0, adj_m = '0, dl_m = '0;
  logic        armed_m = 1'b0, irq_m = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tsc_deadline_timer i_tsc_deadline_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_en_i(tick_en_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  function automatic logic [63:0] vis_m();
    return raw_m + adj_m;
  endfunction

  function automatic logic [63:0] exp_rd(logic [1:0] s);
    case (s)
      2'd0:    return vis_m();
      2'd1:    return adj_m;
      2'd2:    return dl_m;
      default: return {63'd0, armed_m};
    endcase
  endfunction

  function automatic logic [63:0] bnd(int i);
    case (i % 6)
      0:       return 64'h0000_0000_8000_0000;
      1:       return 64'hFFFF_FFFF_0000_0000;
      2:       return 64'hFFFF_FFFE_0000_0000;
      3:       return 64'hFFFF_FFFF_8000_0000;
      4:       return 64'h0000_0000_7FFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  function automatic string rd_req(logic [1:0] s);
    case (s)
      2'd0:    return "R2/R3";
      2'd1:    return "R4";
      2'd2:    return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, model at posedge, check at next negedge
  task automatic cyc(bit tick, bit we, logic [1:0] sel, logic [63:0] data,
                     logic [1:0] rsel, string irq_req);
    logic        fire;
    logic [63:0] raw_n;
    tick_en_i = tick; wr_en_i = we; wr_sel_i = sel; wr_data_i = data; rd_sel_i = rsel;
    @(posedge clk_i);
    fire  = armed_m && (vis_m() >= dl_m) && !(we && sel == 2'd2);
    raw_n = raw_m + {63'd0, tick};
    if (we) begin
      case (sel)
        2'd0: adj_m = data - raw_n;
        2'd1: adj_m = data;
        2'd2: begin dl_m = data; armed_m = (data != 0); end
        default: ;
      endcase
    end
    if (fire) begin armed_m = 1'b0; dl_m = '0; end
    raw_m = raw_n;
    irq_m = fire;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    check(irq_req, {63'd0, irq_o}, {63'd0, irq_m});
    if (irq_o) irq_seen++;
    check(rd_req(rsel), rd_data_o, exp_rd(rsel));
  endtask

  task automatic idle(int n, string req);
    for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, 2'd0, '0, 2'(k % 4), req);
  endtask

  initial begin
    void'($urandom(32'h0000_5EED));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd_sel_i = 2'(s); #1;
      check("R1", rd_data_o, '0);
    end
    check("R1", {63'd0, irq_o}, '0);

    // R2: frozen ticks hold, writes still taken
    for (int k = 0; k < 5; k++) cyc(1'b0, 1'b0, 2'd0, '0, 2'd0, "R2");
    cyc(1'b0, 1'b1, 2'd1, 64'd7, 2'd0, "R2");
    idle(6, "R2");

    // R3: write zero to running counter, offset goes negative
    cyc(1'b1, 1'b1, 2'd0, 64'd0, 2'd0, "R3");
    cyc(1'b1, 1'b0, 2'd0, '0, 2'd1, "R3");
    check("R3", {63'd0, adj_m[63]}, 64'd1);

    // R5: deadline already passed fires next edge
    cyc(1'b1, 1'b1, 2'd2, 64'd1, 2'd3, "R5");
    cyc(1'b1, 1'b0, 2'd0, '0, 2'd2, "R5");
    check("R5", {63'd0, irq_o}, 64'd1);
    idle(4, "R6");

    // R7: zero write in cycle deadline becomes due
    cyc(1'b1, 1'b1, 2'd2, vis_m() + 64'd2, 2'd3, "R7");
    cyc(1'b1, 1'b0, 2'd0, '0, 2'd3, "R7");
    cyc(1'b1, 1'b1, 2'd2, 64'd0, 2'd3, "R7");
    irq_seen = 0;
    idle(8, "R7");
    check("R7", 64'(irq_seen), 64'd0);

    // R8: offset shift after arming pulls firing point in
    cyc(1'b1, 1'b1, 2'd2, vis_m() + 64'd100, 2'd3, "R8");
    cyc(1'b1, 1'b1, 2'd1, adj_m + 64'd95, 2'd0, "R8");
    irq_seen = 0;
    idle(8, "R8");
    check("R8", 64'(irq_seen), 64'd1);

    // R9: status write ignored
    cyc(1'b1, 1'b1, 2'd3, 64'hDEAD_BEEF_0000_FFFF, 2'd1, "R9");
    cyc(1'b1, 1'b0, 2'd0, '0, 2'd3, "R9");

    // R10: boundary offsets, exactly one pulse each
    for (int b = 0; b < 6; b++) begin
      cyc(1'b1, 1'b1, 2'd1, bnd(b), 2'd0, "R10");
      cyc(1'b1, 1'b1, 2'd2, vis_m() + 64'd5, 2'd2, "R10");
      irq_seen = 0;
      idle(12, "R10");
      check("R10", 64'(irq_seen), 64'd1);
    end

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [63:0] d;
      logic [1:0]  sel;
      sel = 2'($urandom % 4);
      case ($urandom % 6)
        0: d = {$urandom, $urandom};
        1: d = vis_m() + 64'($urandom % 16);
        2: d = vis_m() - 64'($urandom % 16);
        3: d = '0;
        4: d = bnd(int'($urandom % 6));
        default: d = 64'($urandom % 32);
      endcase
      cyc(($urandom % 4) != 0, ($urandom % 8) == 0, sel, d,
          2'($urandom % 4), "R5/R6");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule